// File: doc/BRIEF.md
# Multi-segment frequency ramp sequencer

This block produces a frequency-modulation waveform for a fractional-N synthesizer. It updates once per phase-detector clock. It holds a small table of ramp segments. Each segment sets how long it lasts, a signed step, the segment that follows it, whether the offset returns to zero when it ends, and the flag and fast-lock levels it shows while active. A segment either times out after its length or waits for a rising edge on an external trigger line. The block keeps a 30-bit signed frequency offset in fractional-numerator units, in steps of 1/2^24 of the phase-detector rate. The synthesizer's modulator adds this offset to its base numerator.

Software loads the table through a single write port that writes one whole segment per clock. Raising the enable input starts the waveform in segment 0. Chaining segments through their next-pointers builds sawtooth, flattened-triangle and trigger-started patterns. A segment that points to itself repeats forever.

Top module: `fm_ramp_sequencer`

## Requirements
- R1: When cfgWe is high at a clock edge, cfgData is stored as segment cfgAddr. The cfgData bit fields are: length [15:0], increment [45:16], next index [48:46], reset bit [49], flag pattern [51:50] (bit 50 drives flag0 and bit 51 drives flag1), fast-lock [52], trigger-wait [53].
- R2: After any clock edge at which enable is low, segIdx is 0, accOut is 0, and flag0, flag1 and fastLock are low. After reset, every output is 0.
- R3: At every clock edge at which enable is high, the current segment's increment is added to accOut modulo 2^30. An increment of 2^30-2 therefore steps the offset down by 2.
- R4: A segment whose trigger-wait bit is clear stays active for exactly `length` enabled edges and then moves to its next index. A length of 0 behaves as 1, and a segment that names itself repeats.
- R5: On the final edge of a segment whose reset bit is set, accOut is loaded with 0 instead of being incremented.
- R6: A segment whose trigger-wait bit is set stays active until a rising edge of trigIn. If trigIn is first sampled high at edge k, the segment ends at edge k+2. A trigger line held high does not end later waiting segments.
- R7: After an enabled edge, flag0, flag1 and fastLock show the fields of the segment that is then current.
- R8: A one-cycle, zero-increment, trigger-wait segment 0 holds accOut at 0 and segIdx at 0 until the trigger arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase-detector rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the sequencer when high; holds it idle when low |
| trigIn | input | 1 | Asynchronous external trigger line |
| cfgWe | input | 1 | Segment table write strobe |
| cfgAddr | input | 3 | Segment index to write |
| cfgData | input | 54 | Packed segment fields (layout in R1) |
| accOut | output | 30 | Two's-complement frequency offset |
| segIdx | output | 3 | Index of the active segment |
| flag0 | output | 1 | Flag bit 0 of the active segment |
| flag1 | output | 1 | Flag bit 1 of the active segment |
| fastLock | output | 1 | Fast-lock bit of the active segment |

## Verification
Four behaviours are checked by the assertions on every cycle:
- The idle state that follows a disabled edge.
- The exact step of the offset during every enabled cycle of a segment without the reset bit.
- The zero load at a resetting boundary.
- The frozen index of a trigger-wait segment while no trigger edge is seen, together with the single-cycle shape of that edge.

Other behaviours only appear across whole scenarios, so the bench's reference model checks them. These are segment lengths (including the zero-length case), next-pointer chains, wrap-around of negative steps, flag and fast-lock levels, and the two-edge trigger latency. The model runs in step with the design under directed patterns and a long random table.

// File: rtl/ramp_seq_pkg.sv
package ramp_seq_pkg;
  localparam int NUM_SEG = 8;
  localparam int IDX_W   = $clog2(NUM_SEG);
  localparam int LEN_W   = 16;
  localparam int ACC_W   = 30;
  localparam int FLAG_W  = 2;

  // Packed segment descriptor; first member is the most significant.
  typedef struct packed {
    logic              waitTrig;
    logic              fastLock;
    logic [FLAG_W-1:0] flags;
    logic              rstAcc;
    logic [IDX_W-1:0]  nextIdx;
    logic [ACC_W-1:0]  inc;
    logic [LEN_W-1:0]  len;
  } seg_t;

  localparam int SEG_W = $bits(seg_t);

  // Strobes from control to the accumulator datapath.
  typedef struct packed {
    logic clear;
    logic add;
  } acc_strobe_t;
endpackage

// File: rtl/ramp_seg_table.sv
module ramp_seg_table
  import ramp_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrAddr,
  input  seg_t             wrSeg,
  input  logic [IDX_W-1:0] rdIdx,
  output seg_t             rdSeg
);
  seg_t entryQ [NUM_SEG];

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_entry
    seg_t slotQ;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slotQ <= '0;
      end else if (wrEn && (wrAddr == IDX_W'(g))) begin
        slotQ <= wrSeg;
      end
    end
    assign entryQ[g] = slotQ;
  end

  assign rdSeg = entryQ[rdIdx];
endmodule

// File: rtl/ramp_seq_ctrl.sv
module ramp_seq_ctrl
  import ramp_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             trigIn,
  input  logic [LEN_W-1:0] segLen,
  input  logic [IDX_W-1:0] segNext,
  input  logic             segRst,
  input  logic             segWait,
  output logic [IDX_W-1:0] segIdx,
  output logic             lastCyc,
  output logic             runQ,
  output acc_strobe_t      strobe
);
  localparam int SHR_W = SYNC_STAGES + 1;

  logic [SHR_W-1:0] trigShr;
  logic             trigEdge;
  logic [LEN_W-1:0] cycCnt;
  logic [LEN_W-1:0] lenEff;

  // Synchronizer stages plus one history flop for edge detection.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trigShr <= '0;
    end else begin
      trigShr <= {trigShr[SHR_W-2:0], trigIn};
    end
  end

  assign trigEdge = trigShr[SHR_W-2] & ~trigShr[SHR_W-1];

  assign lenEff  = (segLen == '0) ? LEN_W'(1) : segLen;
  assign lastCyc = segWait ? trigEdge : (cycCnt == (lenEff - LEN_W'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      segIdx <= '0;
      cycCnt <= '0;
      runQ   <= 1'b0;
    end else begin
      runQ <= enable;
      if (!enable) begin
        segIdx <= '0;
        cycCnt <= '0;
      end else if (lastCyc) begin
        segIdx <= segNext;
        cycCnt <= '0;
      end else if (!segWait) begin
        cycCnt <= cycCnt + LEN_W'(1);
      end
    end
  end

  always_comb begin
    strobe.clear = !enable || (lastCyc && segRst);
    strobe.add   = !strobe.clear;
  end

  // R6: a waiting segment keeps its index while no edge is seen
  p_wait_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    enable && segWait && !trigEdge |=> segIdx == $past(segIdx));

  // R6: a detected rising edge lasts a single cycle
  p_edge_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    trigEdge |=> !trigEdge);
endmodule

// File: rtl/ramp_acc_dp.sv
module ramp_acc_dp
  import ramp_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  acc_strobe_t      strobe,
  input  logic [ACC_W-1:0] inc,
  output logic [ACC_W-1:0] acc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
    end else if (strobe.clear) begin
      acc <= '0;
    end else if (strobe.add) begin
      acc <= acc + inc;
    end
  end
endmodule

// File: rtl/fm_ramp_sequencer.sv
module fm_ramp_sequencer
  import ramp_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             trigIn,
  input  logic             cfgWe,
  input  logic [IDX_W-1:0] cfgAddr,
  input  logic [SEG_W-1:0] cfgData,
  output logic [ACC_W-1:0] accOut,
  output logic [IDX_W-1:0] segIdx,
  output logic             flag0,
  output logic             flag1,
  output logic             fastLock
);
  seg_t        wrSeg;
  seg_t        curSeg;
  acc_strobe_t strobe;
  logic        lastCyc;
  logic        runQ;

  assign wrSeg = seg_t'(cfgData);

  ramp_seg_table u_table (
    .clk    (clk),
    .rst_n  (rst_n),
    .wrEn   (cfgWe),
    .wrAddr (cfgAddr),
    .wrSeg  (wrSeg),
    .rdIdx  (segIdx),
    .rdSeg  (curSeg)
  );

  ramp_seq_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (enable),
    .trigIn  (trigIn),
    .segLen  (curSeg.len),
    .segNext (curSeg.nextIdx),
    .segRst  (curSeg.rstAcc),
    .segWait (curSeg.waitTrig),
    .segIdx  (segIdx),
    .lastCyc (lastCyc),
    .runQ    (runQ),
    .strobe  (strobe)
  );

  ramp_acc_dp u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (strobe),
    .inc    (curSeg.inc),
    .acc    (accOut)
  );

  assign flag0    = runQ & curSeg.flags[0];
  assign flag1    = runQ & curSeg.flags[1];
  assign fastLock = runQ & curSeg.fastLock;

  // R2: a disabled edge leaves the block idle
  p_idle_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (segIdx == '0) && (accOut == '0) && !flag0 && !flag1 && !fastLock);

  // R3: without a reset bit every enabled edge adds the step
  p_acc_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    enable && !curSeg.rstAcc |=> accOut == $past(accOut + curSeg.inc));

  // R5: a resetting boundary leaves the offset at zero
  p_zero_at_boundary_r5: assert property (@(posedge clk) disable iff (!rst_n)
    enable && lastCyc && curSeg.rstAcc |=> accOut == '0);
endmodule

// File: tb/fm_ramp_sequencer_bench.sv
`timescale 1ns/1ps
module fm_ramp_sequencer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        trigIn = 1'b0;
  logic        cfgWe = 1'b0;
  logic [2:0]  cfgAddr = '0;
  logic [53:0] cfgData = '0;
  logic [29:0] accOut;
  logic [2:0]  segIdx;
  logic        flag0, flag1, fastLock;

  int    errors = 0;
  int    checks = 0;
  bit    cmpOn = 1'b0;
  string tag = "R2";
  logic [31:0] rng = 32'h1badcafe;

  // behavioural reference state
  logic [53:0] mTbl [8];
  logic [2:0]  mIdx;
  int          mCnt;
  logic [29:0] mAcc;
  bit          mRun;
  bit          trigHist[$];

  always #4 clk = ~clk;

  fm_ramp_sequencer u_fm_ramp_sequencer (
    .clk(clk), .rst_n(rst_n), .enable(enable), .trigIn(trigIn),
    .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .accOut(accOut), .segIdx(segIdx), .flag0(flag0), .flag1(flag1),
    .fastLock(fastLock)
  );

  function automatic logic [53:0] mkSeg(bit w, bit fl, logic [1:0] f, bit r,
                                        logic [2:0] nx, logic [29:0] inc,
                                        logic [15:0] len);
    return {w, fl, f, r, nx, inc, len};
  endfunction

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeSeg(logic [2:0] a, logic [53:0] d);
    cfgWe = 1'b1; cfgAddr = a; cfgData = d;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  function automatic logic [31:0] nextRng(logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    return y ^ (y << 5);
  endfunction

  // reference model, advanced on each rising edge
  always @(posedge clk) begin
    logic [53:0] s;
    int  lenE;
    bit  edgeSeen, last;
    if (!rst_n) begin
      mIdx = 0; mCnt = 0; mAcc = 0; mRun = 0;
      foreach (mTbl[i]) mTbl[i] = '0;
      trigHist = '{0, 0, 0};
    end else begin
      edgeSeen = trigHist[$-1] && !trigHist[$-2];
      s = mTbl[mIdx];
      if (!enable) begin
        mIdx = 0; mCnt = 0; mAcc = 0;
      end else begin
        lenE = (s[15:0] == 16'd0) ? 1 : int'(s[15:0]);
        last = s[53] ? edgeSeen : (mCnt == lenE - 1);
        if (last) begin
          mAcc = s[49] ? 30'd0 : mAcc + s[45:16];
          mIdx = s[48:46];
          mCnt = 0;
        end else begin
          mAcc = mAcc + s[45:16];
          if (!s[53]) mCnt = mCnt + 1;
        end
      end
      mRun = enable;
      if (cfgWe) mTbl[cfgAddr] = cfgData;
      trigHist.push_back(trigIn);
      if (trigHist.size() > 4) void'(trigHist.pop_front());
    end
  end

  // per-cycle comparison against the model (R3 R4 R7)
  always @(negedge clk) begin
    if (rst_n && cmpOn) begin
      chk(tag, "model accOut", accOut, mAcc);
      chk(tag, "model segIdx", segIdx, mIdx);
      chk(tag, "model flag0", flag0, mRun & mTbl[mIdx][50]);
      chk(tag, "model flag1", flag1, mRun & mTbl[mIdx][51]);
      chk(tag, "model fastLock", fastLock, mRun & mTbl[mIdx][52]);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    cyc(3);
    chk("R2", "reset accOut", accOut, 0);
    chk("R2", "reset segIdx", segIdx, 0);
    chk("R2", "reset flags", {flag1, flag0, fastLock}, 0);
    rst_n = 1'b1;
    cyc(1);
    cmpOn = 1'b1;

    // sawtooth: length 4, step 5, self-loop with reset
    tag = "R5";
    writeSeg(0, mkSeg(0, 0, 2'b01, 1, 0, 30'd5, 16'd4));
    enable = 1'b1;
    cyc(1); chk("R3", "saw first step", accOut, 5);
    cyc(2); chk("R3", "saw third step", accOut, 15);
    cyc(1); chk("R5", "saw zero at boundary", accOut, 0);
            chk("R4", "saw self loop idx", segIdx, 0);
    cyc(1); chk("R4", "saw repeats", accOut, 5);
            chk("R7", "saw flag0", flag0, 1);
            chk("R7", "saw flag1", flag1, 0);
    enable = 1'b0;
    cyc(1);
    chk("R2", "off accOut", accOut, 0);
    chk("R2", "off flags", {flag1, flag0, fastLock}, 0);

    // chain with a negative step and a zero-length segment
    tag = "R4";
    writeSeg(0, mkSeg(0, 0, 2'b00, 1, 1, 30'd0, 16'd1));
    writeSeg(1, mkSeg(0, 1, 2'b10, 0, 2, 30'h3FFFFFFE, 16'd3));
    writeSeg(2, mkSeg(0, 0, 2'b11, 0, 1, 30'd7, 16'd0));
    enable = 1'b1;
    cyc(1); chk("R4", "chain enters seg1", segIdx, 1);
            chk("R5", "chain start zero", accOut, 0);
    cyc(1); chk("R3", "wrap negative step", accOut, 30'h3FFFFFFE);
            chk("R1", "flag1 field bit51", flag1, 1);
            chk("R1", "flag0 field bit50", flag0, 0);
            chk("R7", "fastLock field", fastLock, 1);
    cyc(2); chk("R4", "seg1 length 3", segIdx, 2);
            chk("R3", "three down steps", accOut, 30'h3FFFFFFA);
    cyc(1); chk("R4", "zero length acts as one", segIdx, 1);
            chk("R3", "wrap back positive", accOut, 1);
    enable = 1'b0;
    cyc(1);

    // trigger-started waveform
    tag = "R6";
    writeSeg(0, mkSeg(1, 0, 2'b11, 1, 1, 30'd0, 16'd1));
    writeSeg(1, mkSeg(0, 0, 2'b00, 1, 0, 30'd100, 16'd3));
    enable = 1'b1;
    cyc(10);
    chk("R8", "idle seg while waiting", segIdx, 0);
    chk("R8", "idle acc while waiting", accOut, 0);
    chk("R7", "wait seg flags", {flag1, flag0}, 3);
    trigIn = 1'b1;
    cyc(1); chk("R6", "no advance at k", segIdx, 0);
    cyc(1); chk("R6", "no advance at k+1", segIdx, 0);
    cyc(1); chk("R6", "advance at k+2", segIdx, 1);
    cyc(2); chk("R3", "triggered ramp", accOut, 200);
    cyc(1); chk("R5", "triggered ramp reset", accOut, 0);
    cyc(5); chk("R6", "held level no retrigger", segIdx, 0);
    trigIn = 1'b0;
    enable = 1'b0;
    cyc(1);

    // random tables checked cycle by cycle against the model
    tag = "R4";
    for (int r = 0; r < 6; r++) begin
      enable = 1'b0;
      for (int a = 0; a < 8; a++) begin
        logic [53:0] d;
        rng = nextRng(rng); d[31:0] = rng;
        rng = nextRng(rng); d[53:32] = rng[21:0];
        d[15:0] = {13'd0, d[2:0]};
        d[53] = (rng[31:29] == 3'd0);
        writeSeg(a[2:0], d);
      end
      enable = 1'b1;
      for (int c = 0; c < 500; c++) begin
        rng = nextRng(rng);
        if (rng[3:0] == 4'd0) trigIn = ~trigIn;
        enable = (rng[15:8] != 8'd0);
        cyc(1);
      end
    end
    enable = 1'b0;
    cyc(2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule